// File: doc/BRIEF.md
# Fractional Rate Clock-Enable Generator

This block turns a free-running reference clock into a stream of single-cycle enable pulses. The average pulse rate is m/n times the reference rate. A phase accumulator produces the pulses: each reference cycle it adds m, and whenever the sum reaches n it takes n away and raises the enable for that cycle. Logic clocked by the reference and gated by the enable then runs at the fractional rate.

Software sets m and n through a small register port. The port has a low register that holds the lower bits of both terms and a high register that holds their upper bits. A write to the high register only loads a pending copy. The next low-register write moves the pending high bits and the new low bits into the active ratio on the same edge, so the ratio never changes half-written. The block falls back to a pass-through mode (enable high every cycle) when either term is zero or when m is not below n. A parameter selects an encoding in which every stored field means its value plus one. A status output marks numerators from 1 to 3, because a downstream fine-compensation stage drops the two lowest numerator bits.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset both active fields are zero, reads of both addresses return zero and, with the plus-one encoding off, the enable output is high every cycle.
- R2: Address 0 (low) holds m[15:0] at data bits [15:0] and n[15:0] at bits [31:16]. Address 1 (high) holds m[HI_W+15:16] at bits [HI_W-1:0] and n[HI_W+15:16] at bits [HI_W+15:16]. All other bits read as zero, and reads are combinational.
- R3: A high-register write only updates a pending copy. Readback of both addresses and the active ratio stay unchanged until the next low-register write.
- R4: A low-register write commits the pending high bits and the written low bits together at that clock edge and clears the accumulator to zero.
- R5: Outside pass-through, in the j-th cycle after a commit (j = 1, 2, ...) the enable is high exactly when floor(j*m/n) > floor((j-1)*m/n). Over K cycles this gives floor(K*m/n) pulses.
- R6: When the effective m or n is zero, pass-through is active and the enable is high every cycle.
- R7: When the effective m is at least the effective n, pass-through is active and the enable is high every cycle.
- R8: With parameter ZERO_BASED = 1, the effective m and n are the stored fields plus one.
- R9: The low-numerator flag is high exactly when the effective m is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 low, 1 high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Committed field values of the selected register |
| clk_en_out | output | 1 | Fractional-rate enable pulse |
| bypass_active | output | 1 | Pass-through mode in effect |
| low_num_flag | output | 1 | Effective numerator is 1 to 3 |

## Verification
A corrupted accumulator shows up within one ratio period as a pulse in the wrong cycle. The bench compares the enable cycle by cycle from the commit onward, so any drift is caught at the first misplaced pulse rather than only in a total count. A high write that leaks into the active ratio appears immediately on the combinational readback before the low write. A commit that fails to clear the phase shifts the very first pulse after the low write. Pass-through decode errors show as a single low enable cycle where the bench expects a solid high level.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  // effective term from a stored field, optional plus-one encoding
  function automatic logic [32:0] eff_term(input logic [31:0] field, input logic plus_one);
    return {1'b0, field} + {32'd0, plus_one};
  endfunction

  // pass-through when a term is zero or the ratio is not below one
  function automatic logic pass_through(input logic [32:0] m, input logic [32:0] n);
    return (m == '0) || (n == '0) || (m >= n);
  endfunction

  // numerator small enough to be damaged by the dropped LSB pair
  function automatic logic tiny_num(input logic [32:0] m);
    return (m != '0) && (m < 33'd4);
  endfunction
endpackage

// File: rtl/frac_rate_regs.sv
module frac_rate_regs #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int FW = LO_W + HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [FW-1:0] m_act,
  output logic [FW-1:0] n_act,
  output logic          commit
);
  logic [HI_W-1:0] m_pend, n_pend;
  logic            hi_wr;

  assign hi_wr  = wr_en && addr;
  assign commit = wr_en && !addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0;
      n_pend <= '0;
      m_act  <= '0;
      n_act  <= '0;
    end else if (hi_wr) begin
      m_pend <= wdata[HI_W-1:0];
      n_pend <= wdata[16 +: HI_W];
    end else if (commit) begin
      m_act <= {m_pend, wdata[LO_W-1:0]};
      n_act <= {n_pend, wdata[16 +: LO_W]};
    end
  end

  always_comb begin
    rdata = '0;
    if (addr) begin
      rdata[HI_W-1:0]   = m_act[FW-1:LO_W];
      rdata[16 +: HI_W] = n_act[FW-1:LO_W];
    end else begin
      rdata[LO_W-1:0]   = m_act[LO_W-1:0];
      rdata[16 +: LO_W] = n_act[LO_W-1:0];
    end
  end

  p_high_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> ($stable(m_act) && $stable(n_act)));
endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum #(
  parameter int EW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          bypass,
  input  logic [EW-1:0] m_eff,
  input  logic [EW-1:0] n_eff,
  output logic          pulse
);
  logic [EW-1:0] acc_q;
  logic [EW:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, m_eff};
  assign pulse = !bypass && (sum >= {1'b0, n_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               acc_q <= '0;
    else if (commit || bypass) acc_q <= '0;
    else if (pulse)           acc_q <= EW'(sum - {1'b0, n_eff});
    else                      acc_q <= EW'(sum);
  end

  p_commit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (acc_q == '0));
  p_phase_below_n_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (acc_q < n_eff));
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen #(
  parameter int LO_W       = 16,
  parameter int HI_W       = 4,
  parameter bit ZERO_BASED = 1'b0,
  localparam int FW = LO_W + HI_W,
  localparam int EW = FW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        clk_en_out,
  output logic        bypass_active,
  output logic        low_num_flag
);
  import frac_rate_pkg::*;

  logic [FW-1:0] m_act, n_act;
  logic          commit, pulse;
  logic [32:0]   m_wide, n_wide;
  logic [EW-1:0] m_eff, n_eff;

  frac_rate_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .m_act(m_act), .n_act(n_act), .commit(commit)
  );

  assign m_wide        = eff_term(32'(m_act), ZERO_BASED);
  assign n_wide        = eff_term(32'(n_act), ZERO_BASED);
  assign m_eff         = m_wide[EW-1:0];
  assign n_eff         = n_wide[EW-1:0];
  assign bypass_active = pass_through(m_wide, n_wide);
  assign low_num_flag  = tiny_num(m_wide);

  frac_rate_accum #(.EW(EW)) u_accum (
    .clk(clk), .rst_n(rst_n), .commit(commit), .bypass(bypass_active),
    .m_eff(m_eff), .n_eff(n_eff), .pulse(pulse)
  );

  assign clk_en_out = bypass_active || pulse;

  p_bypass_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_active |-> clk_en_out);
  p_flag_vs_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_num_flag && !bypass_active) |-> (n_eff > m_eff));
endmodule

// File: tb/frac_rate_gen_tb.sv
module frac_rate_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        en_a, en_b, byp_a, byp_b, flg_a, flg_b;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  frac_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .addr(addr), .wdata(wdata),
    .rdata(rd_a), .clk_en_out(en_a), .bypass_active(byp_a), .low_num_flag(flg_a));

  frac_rate_gen #(.ZERO_BASED(1'b1)) u_dut_zb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .addr(addr), .wdata(wdata),
    .rdata(rd_b), .clk_en_out(en_b), .bypass_active(byp_b), .low_num_flag(flg_b));

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write one register; returns at the negedge right after the commit edge
  task automatic wr(input bit zb, input logic a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (zb) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit zb, input logic a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check((zb ? rd_b : rd_a) === exp, req, zb ? rd_b : rd_a, exp);
  endtask

  // commit m/n via low write, then compare the enable every cycle
  task automatic ratio(input bit zb, input longint m, input longint n, input int k, input string req);
    logic en, exp;
    wr(zb, 1'b0, {n[15:0], m[15:0]});
    for (int j = 1; j <= k; j++) begin
      if (j > 1) @(negedge clk);
      en  = zb ? en_b : en_a;
      exp = ((longint'(j) * m) / n) != ((longint'(j - 1) * m) / n);
      check(en === exp, req, en, exp);
    end
  endtask

  task automatic solid(input int k, input string req);
    for (int j = 0; j < k; j++) begin
      check(en_a === 1'b1 && byp_a === 1'b1, req, en_a, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rd(0, 1'b0, 32'h0, "R1");
    rd(0, 1'b1, 32'h0, "R1");
    solid(5, "R1");
  endtask

  task automatic t_rates();
    ratio(0, 3, 7, 40, "R5");
    ratio(0, 1, 2, 12, "R5");
    ratio(0, 5, 16, 48, "R5");
    ratio(0, 11, 13, 30, "R5");
  endtask

  task automatic t_staging();
    wr(0, 1'b0, {16'd9, 16'd4});
    wr(0, 1'b1, 32'h0003_0001);
    rd(0, 1'b1, 32'h0, "R3");
    rd(0, 1'b0, {16'd9, 16'd4}, "R3");
    ratio(0, 65536, 196608, 30, "R4");
    rd(0, 1'b1, 32'h0003_0001, "R2");
    rd(0, 1'b0, 32'h0, "R2");
  endtask

  task automatic t_bypass();
    wr(0, 1'b1, 32'h0);
    wr(0, 1'b0, {16'd8, 16'd0});  solid(6, "R6");
    wr(0, 1'b0, {16'd0, 16'd5});  solid(6, "R6");
    wr(0, 1'b0, {16'd7, 16'd7});  solid(6, "R7");
    wr(0, 1'b0, {16'd5, 16'd9});  solid(6, "R7");
  endtask

  task automatic t_flag();
    wr(0, 1'b0, {16'd10, 16'd3}); #1; check(flg_a === 1'b1, "R9", flg_a, 1);
    wr(0, 1'b0, {16'd10, 16'd1}); #1; check(flg_a === 1'b1, "R9", flg_a, 1);
    wr(0, 1'b0, {16'd10, 16'd4}); #1; check(flg_a === 1'b0, "R9", flg_a, 0);
    wr(0, 1'b0, {16'd10, 16'd0}); #1; check(flg_a === 1'b0, "R9", flg_a, 0);
  endtask

  task automatic t_zero_based();
    #1;
    check(en_b === 1'b1 && byp_b === 1'b1, "R8", en_b, 1);
    check(flg_b === 1'b1, "R8", flg_b, 1);
    ratio(1, 2, 6, 1, "R8");  // only commits; pattern below uses effective terms
    for (int j = 2; j <= 30; j++) begin
      logic exp;
      @(negedge clk);
      exp = ((j * 3) / 7) != (((j - 1) * 3) / 7);
      check(en_b === exp, "R8", en_b, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_staging();
        t_bypass();
        t_flag();
        wr(1, 1'b1, 32'h0);
        t_zero_based();
      end
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule